// File: doc/BRIEF.md
# Power-Register Access Message Engine

This engine sits on the controller side of a host mailbox. It carries out register-access messages against a small internal register file. Each register is one byte wide and has a 16-bit address. The host first places a payload in the mailbox write buffer. It then strobes `start` together with a 32-bit command word. The engine copies the payload into local storage, one byte per clock. It then performs the requested accesses, one register per clock, and signals completion with a one-cycle `done` pulse and an `err` flag.

Three operations are supported. A read fetches up to five registers and places the results in the mailbox read buffer. A write stores up to five data bytes. A masked read-modify-write updates only the selected bits of one register. Malformed or foreign messages are refused before any register is touched. An address outside the implemented range stops the message at that element.

Top module: `pwr_msg_engine`

## Requirements
- R1: The command word holds the message type in bits 7:0, the operation code in bits 15:12 and the payload size in bytes in bits 23:16. Only type 0xFF is served. Any other type ends with `err` set and no register changed.
- R2: Operation code 0 writes, 1 reads, and 2 performs a masked read-modify-write. Any other code ends with `err` set and no register changed.
- R3: Register address i of a message is taken from payload bytes 2i (low byte) and 2i+1 (high byte), so the addresses are packed little-endian from byte 0.
- R4: A read of N registers has a payload size of 2N. Result byte i is written to read-buffer byte i, in address-list order, and nothing else is written to the read buffer.
- R5: A write of N registers has a payload size of 3N. The data byte for address i is payload byte 2N+i.
- R6: N must lie between 1 and MAX_REGS (5). A count outside that range, or a size that is not 2N for a read or 3N for a write, sets `err` and performs no access.
- R7: A read-modify-write has a payload size of exactly 4: address in bytes 0 and 1, new value in byte 2, mask in byte 3. A mask bit of 1 takes the new value and a mask bit of 0 keeps the old bit. Any other size sets `err`.
- R8: An address of REG_DEPTH (64) or above sets `err` and skips that element and every later one. Accesses already made to earlier elements remain in effect.
- R9: A `start` is accepted only while the engine is idle (neither `busy` nor `done`). `busy` is high during the size-cycle payload load and the N-cycle access phase. `done` is then high for exactly one cycle with `busy` low, so `done` appears size+N+1 clock edges after the accepting edge. A refused message pulses `done` right after the accepting edge. A `start` raised while `busy` is high is ignored.
- R10: After reset, `busy`, `done` and `err` are low and every register holds 0. `err` keeps its value from the `done` pulse until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Message strobe, taken while idle |
| cmd_word | input | 32 | Command word: type, operation code and size |
| wbuf_addr | output | 5 | Byte index into the mailbox write buffer |
| wbuf_data | input | 8 | Write-buffer byte at `wbuf_addr`, same cycle |
| rbuf_we | output | 1 | Read-buffer byte write enable |
| rbuf_addr | output | 5 | Read-buffer byte index |
| rbuf_data | output | 8 | Read-buffer byte value |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure status of the last message |

## Verification
The hardest case to provoke is the mid-message abort. An out-of-range address has to sit between valid ones so that the bench can see both the access made before it and the access skipped after it. The stimulus is a three-element write whose middle address is exactly REG_DEPTH. Read-back then shows that the first register took its data and the third kept its old value, and the `done` cycle count shows where the message stopped. A second `start` issued while the engine is still loading shows that a request arriving mid-flight neither disturbs the running message nor changes its error status.

// File: rtl/pme_pkg.sv
package pme_pkg;

    localparam logic [7:0] MSG_PWR_REG = 8'hFF;

    localparam logic [3:0] OPC_WRITE = 4'd0;
    localparam logic [3:0] OPC_READ  = 4'd1;
    localparam logic [3:0] OPC_RMW   = 4'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EXEC,
        ST_FIN
    } pme_state_e;

    typedef enum logic [1:0] {
        ACC_WR,
        ACC_RD,
        ACC_RMW
    } acc_kind_e;

    typedef struct packed {
        logic [7:0] msg;
        logic [3:0] opc;
        logic [7:0] size;
    } cmd_fields_t;

    function automatic cmd_fields_t split_cmd(input logic [31:0] w);
        cmd_fields_t f;
        f.msg  = w[7:0];
        f.opc  = w[15:12];
        f.size = w[23:16];
        return f;
    endfunction

    function automatic logic [7:0] masked_merge(input logic [7:0] old_v,
                                                input logic [7:0] new_v,
                                                input logic [7:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/pme_decode.sv
module pme_decode
    import pme_pkg::*;
#(
    parameter int MAX_REGS = 5,
    parameter int CNT_W    = 3
) (
    input  cmd_fields_t      fields,
    output logic             ok,
    output acc_kind_e        kind,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        ok    = 1'b0;
        kind  = ACC_RD;
        count = '0;
        if (fields.msg == MSG_PWR_REG) begin
            case (fields.opc)
                OPC_WRITE: begin
                    kind = ACC_WR;
                    for (int n = 1; n <= MAX_REGS; n++) begin
                        if (fields.size == 8'(3 * n)) begin
                            ok    = 1'b1;
                            count = CNT_W'(n);
                        end
                    end
                end
                OPC_READ: begin
                    kind = ACC_RD;
                    for (int n = 1; n <= MAX_REGS; n++) begin
                        if (fields.size == 8'(2 * n)) begin
                            ok    = 1'b1;
                            count = CNT_W'(n);
                        end
                    end
                end
                OPC_RMW: begin
                    kind = ACC_RMW;
                    if (fields.size == 8'd4) begin
                        ok    = 1'b1;
                        count = CNT_W'(1);
                    end
                end
                default: ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pme_payload.sv
module pme_payload #(
    parameter int PL_BYTES = 15,
    parameter int PIW      = 4,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             load_en,
    input  logic [PIW-1:0]   load_idx,
    input  logic [7:0]       load_byte,
    input  logic [PIW-1:0]   sel,
    input  logic [CNT_W-1:0] count,
    output logic [15:0]      elem_addr,
    output logic [7:0]       elem_data,
    output logic [7:0]       elem_mask
);

    logic [7:0] pl [PL_BYTES];
    logic [PIW-1:0] lo_i, hi_i, d_i;

    always_ff @(posedge clk) begin
        if (load_en) begin
            pl[load_idx] <= load_byte;
        end
    end

    always_comb begin
        lo_i      = PIW'(2 * int'(sel));
        hi_i      = PIW'(2 * int'(sel) + 1);
        d_i       = PIW'(2 * int'(count) + int'(sel));
        elem_addr = {pl[hi_i], pl[lo_i]};
        elem_data = pl[d_i];
        elem_mask = pl[3];
    end

endmodule

// File: rtl/pme_regfile.sv
module pme_regfile #(
    parameter int DEPTH = 64,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          in_range,
    input  logic          we,
    input  logic [7:0]    wr_data
);

    localparam int IW = $clog2(DEPTH);
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    logic [7:0] mem [DEPTH];
    logic [IW-1:0] idx;

    assign in_range = rd_addr < DEPTH_A;
    assign idx      = rd_addr[IW-1:0];
    assign rd_data  = in_range ? mem[idx] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= 8'h00;
            end
        end else if (we && in_range) begin
            mem[idx] <= wr_data;
        end
    end

endmodule

// File: rtl/pwr_msg_engine.sv
module pwr_msg_engine
    import pme_pkg::*;
#(
    parameter int MAX_REGS  = 5,
    parameter int BUF_BYTES = 20,
    parameter int REG_DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [31:0]                  cmd_word,
    output logic [$clog2(BUF_BYTES)-1:0] wbuf_addr,
    input  logic [7:0]                   wbuf_data,
    output logic                         rbuf_we,
    output logic [$clog2(BUF_BYTES)-1:0] rbuf_addr,
    output logic [7:0]                   rbuf_data,
    output logic                         busy,
    output logic                         done,
    output logic                         err
);

    localparam int WB_AW    = $clog2(BUF_BYTES);
    localparam int PL_BYTES = 3 * MAX_REGS;
    localparam int PIW      = $clog2(PL_BYTES + 1);
    localparam int CNT_W    = $clog2(MAX_REGS + 1);

    pme_state_e       state;
    logic [PIW-1:0]   idx;
    logic [PIW-1:0]   size_q;
    logic [CNT_W-1:0] cnt_q;
    acc_kind_e        kind_q;
    logic             err_q;

    cmd_fields_t      fields;
    logic             dec_ok;
    acc_kind_e        dec_kind;
    logic [CNT_W-1:0] dec_cnt;

    logic [15:0]      elem_addr;
    logic [7:0]       elem_data, elem_mask;
    logic [7:0]       rf_rd_data, rf_wr_data;
    logic             rf_in_range, rf_we;
    logic             unused_cmd_bits;

    assign fields          = split_cmd(cmd_word);
    assign unused_cmd_bits = ^{cmd_word[31:24], cmd_word[11:8]};

    pme_decode #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) i_decode (
        .fields (fields),
        .ok     (dec_ok),
        .kind   (dec_kind),
        .count  (dec_cnt)
    );

    pme_payload #(.PL_BYTES(PL_BYTES), .PIW(PIW), .CNT_W(CNT_W)) i_payload (
        .clk       (clk),
        .load_en   (state == ST_LOAD),
        .load_idx  (idx),
        .load_byte (wbuf_data),
        .sel       (idx),
        .count     (cnt_q),
        .elem_addr (elem_addr),
        .elem_data (elem_data),
        .elem_mask (elem_mask)
    );

    pme_regfile #(.DEPTH(REG_DEPTH), .AW(16)) i_regfile (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (elem_addr),
        .rd_data  (rf_rd_data),
        .in_range (rf_in_range),
        .we       (rf_we),
        .wr_data  (rf_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            size_q <= '0;
            cnt_q  <= '0;
            kind_q <= ACC_RD;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        err_q  <= !dec_ok;
                        kind_q <= dec_kind;
                        cnt_q  <= dec_cnt;
                        size_q <= PIW'(fields.size);
                        idx    <= '0;
                        state  <= dec_ok ? ST_LOAD : ST_FIN;
                    end
                end
                ST_LOAD: begin
                    if (idx == size_q - PIW'(1)) begin
                        idx   <= '0;
                        state <= ST_EXEC;
                    end else begin
                        idx <= idx + PIW'(1);
                    end
                end
                ST_EXEC: begin
                    if (!rf_in_range) begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                    end else if (idx == PIW'(cnt_q) - PIW'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        idx <= idx + PIW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rf_we      = (state == ST_EXEC) && rf_in_range && (kind_q != ACC_RD);
        rf_wr_data = (kind_q == ACC_RMW) ? masked_merge(rf_rd_data, elem_data, elem_mask)
                                         : elem_data;
        rbuf_we    = (state == ST_EXEC) && rf_in_range && (kind_q == ACC_RD);
        rbuf_addr  = WB_AW'(idx);
        rbuf_data  = rf_rd_data;
        wbuf_addr  = WB_AW'(idx);
        busy       = (state == ST_LOAD) || (state == ST_EXEC);
        done       = (state == ST_FIN);
        err        = err_q;
    end

endmodule

// File: rtl/pme_chk.sv
module pme_chk #(
    parameter int MAX_REGS = 5,
    parameter int AW       = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [31:0]   cmd_word,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          rbuf_we,
    input logic [AW-1:0] rbuf_addr,
    input logic          rf_we
);

    localparam logic [AW-1:0] MAX_A = AW'(MAX_REGS);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R1
    bad_type_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && cmd_word[7:0] != 8'hFF) |=> (done && err));

    // R2
    bad_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && cmd_word[7:0] == 8'hFF && cmd_word[15:12] > 4'd2)
        |=> (done && err));

    // R4
    rbuf_range_chk: assert property (@(posedge clk) disable iff (rst)
        rbuf_we |-> (busy && rbuf_addr < MAX_A));

    // R6
    reg_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> busy);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !start) |=> $stable(err));

endmodule

bind pwr_msg_engine pme_chk #(.MAX_REGS(MAX_REGS), .AW($clog2(BUF_BYTES))) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rbuf_we   (rbuf_we),
    .rbuf_addr (rbuf_addr),
    .rf_we     (rf_we)
);

// File: tb/test_pwr_msg_engine.sv
module test_pwr_msg_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [4:0]  wbuf_addr;
    logic [7:0]  wbuf_data;
    logic        rbuf_we;
    logic [4:0]  rbuf_addr;
    logic [7:0]  rbuf_data;
    logic        busy, done, err;

    logic [7:0] wb [20];
    logic [7:0] rb [20];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign wbuf_data = wb[wbuf_addr];

    always @(posedge clk) begin
        if (rbuf_we) rb[rbuf_addr] <= rbuf_data;
    end

    pwr_msg_engine i_pwr_msg_engine (
        .clk(clk), .rst(rst), .start(start), .cmd_word(cmd_word),
        .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
        .rbuf_we(rbuf_we), .rbuf_addr(rbuf_addr), .rbuf_data(rbuf_data),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcmd(input logic [7:0] typ, input logic [3:0] opc,
                                          input logic [7:0] size);
        return {8'h00, size, opc, 4'h0, typ};
    endfunction

    task automatic clear_rb();
        for (int k = 0; k < 20; k++) rb[k] = 8'hAA;
    endtask

    task automatic run(input logic [31:0] cmd, output int cyc, output logic e);
        @(negedge clk);
        cmd_word = cmd;
        start = 1'b1;
        cyc = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) break;
        end
        e = err;
    endtask

    task automatic rd1(input logic [15:0] a, output logic [7:0] v);
        int c;
        logic e;
        clear_rb();
        wb[0] = a[7:0];
        wb[1] = a[15:8];
        run(mkcmd(8'hFF, 4'd1, 8'd2), c, e);
        v = rb[0];
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R10 busy after reset", busy, 0);
        check("R10 done after reset", done, 0);
        check("R10 err after reset", err, 0);
        rd1(16'h0007, v);
        check("R10 register cleared", v, 8'h00);
    endtask

    task automatic t_write_read();
        int c;
        logic e;
        wb[0] = 8'h05; wb[1] = 8'h00; wb[2] = 8'h10; wb[3] = 8'h00;
        wb[4] = 8'h3F; wb[5] = 8'h00; wb[6] = 8'h11; wb[7] = 8'h22; wb[8] = 8'h33;
        run(mkcmd(8'hFF, 4'd0, 8'd9), c, e);
        check("R5 write err", e, 0);
        check("R9 write done cycle", c, 13);
        check("R9 busy low at done", busy, 0);
        clear_rb();
        wb[0] = 8'h3F; wb[1] = 8'h00; wb[2] = 8'h05; wb[3] = 8'h00;
        wb[4] = 8'h10; wb[5] = 8'h00;
        run(mkcmd(8'hFF, 4'd1, 8'd6), c, e);
        check("R4 read err", e, 0);
        check("R9 read done cycle", c, 10);
        check("R4 R3 rbuf byte 0", rb[0], 8'h33);
        check("R4 R3 rbuf byte 1", rb[1], 8'h11);
        check("R4 R3 rbuf byte 2", rb[2], 8'h22);
        check("R4 rbuf byte 3 untouched", rb[3], 8'hAA);
    endtask

    task automatic t_counts();
        int c;
        logic e;
        logic [7:0] v;
        for (int k = 0; k < 5; k++) begin
            wb[2*k] = 8'(20 + k); wb[2*k+1] = 8'h00; wb[10+k] = 8'(8'hA0 + k);
        end
        run(mkcmd(8'hFF, 4'd0, 8'd15), c, e);
        check("R6 five-register write err", e, 0);
        clear_rb();
        run(mkcmd(8'hFF, 4'd1, 8'd10), c, e);
        check("R6 five-register read err", e, 0);
        check("R6 five-register read byte 4", rb[4], 8'hA4);
        for (int k = 0; k < 6; k++) begin
            wb[2*k] = 8'd20; wb[2*k+1] = 8'h00; wb[12+k] = 8'h5A;
        end
        run(mkcmd(8'hFF, 4'd0, 8'd18), c, e);
        check("R6 six-register err", e, 1);
        check("R6 six-register done cycle", c, 1);
        rd1(16'd20, v);
        check("R6 six-register no write", v, 8'hA0);
        run(mkcmd(8'hFF, 4'd1, 8'd0), c, e);
        check("R6 zero count err", e, 1);
        run(mkcmd(8'hFF, 4'd0, 8'd7), c, e);
        check("R6 size mismatch err", e, 1);
        rd1(16'd20, v);
        check("R6 size mismatch no write", v, 8'hA0);
    endtask

    task automatic t_rmw();
        int c;
        logic e;
        logic [7:0] v;
        wb[0] = 8'h05; wb[1] = 8'h00; wb[2] = 8'hF0; wb[3] = 8'h3C;
        run(mkcmd(8'hFF, 4'd2, 8'd4), c, e);
        check("R7 rmw err", e, 0);
        check("R7 rmw done cycle", c, 6);
        rd1(16'h0005, v);
        check("R7 masked merge", v, 8'h31);
        wb[0] = 8'h05; wb[1] = 8'h00; wb[2] = 8'hFF;
        run(mkcmd(8'hFF, 4'd2, 8'd3), c, e);
        check("R7 rmw bad size err", e, 1);
        rd1(16'h0005, v);
        check("R7 rmw bad size no change", v, 8'h31);
    endtask

    task automatic t_reject();
        int c;
        logic e;
        logic [7:0] v;
        wb[0] = 8'h10; wb[1] = 8'h00; wb[2] = 8'h99;
        run(mkcmd(8'hFE, 4'd0, 8'd3), c, e);
        check("R1 foreign type err", e, 1);
        check("R1 foreign type done cycle", c, 1);
        rd1(16'h0010, v);
        check("R1 foreign type no write", v, 8'h22);
        run(mkcmd(8'hFF, 4'd3, 8'd3), c, e);
        check("R2 unknown opcode err", e, 1);
        rd1(16'h0010, v);
        check("R2 unknown opcode no write", v, 8'h22);
    endtask

    task automatic t_range();
        int c;
        logic e;
        logic [7:0] v;
        wb[0] = 8'h30; wb[1] = 8'h00; wb[2] = 8'h40; wb[3] = 8'h00;
        wb[4] = 8'h31; wb[5] = 8'h00; wb[6] = 8'h55; wb[7] = 8'h66; wb[8] = 8'h77;
        run(mkcmd(8'hFF, 4'd0, 8'd9), c, e);
        check("R8 abort err", e, 1);
        check("R8 abort done cycle", c, 12);
        rd1(16'h0030, v);
        check("R8 earlier write kept", v, 8'h55);
        rd1(16'h0031, v);
        check("R8 later write skipped", v, 8'h00);
        clear_rb();
        wb[0] = 8'h05; wb[1] = 8'h01;
        run(mkcmd(8'hFF, 4'd1, 8'd2), c, e);
        check("R8 R3 high address byte out of range", e, 1);
        check("R8 no read-buffer write", rb[0], 8'hAA);
    endtask

    task automatic t_busy_ignore();
        int c;
        logic e;
        clear_rb();
        wb[0] = 8'h05; wb[1] = 8'h00;
        run(mkcmd(8'hFF, 4'd1, 8'd2), c, e);
        check("R10 err set by range abort is cleared", e, 0);
        clear_rb();
        @(negedge clk);
        cmd_word = mkcmd(8'hFF, 4'd1, 8'd2);
        start = 1'b1;
        @(negedge clk);
        cmd_word = mkcmd(8'h00, 4'd0, 8'd3);
        @(negedge clk);
        start = 1'b0;
        c = 2;
        for (int k = 0; k < 50; k++) begin
            if (done) break;
            @(negedge clk);
            c++;
        end
        check("R9 ignored start done cycle", c, 4);
        check("R9 ignored start err", err, 0);
        check("R9 ignored start result", rb[0], 8'h31);
        run(mkcmd(8'h00, 4'd0, 8'd3), c, e);
        check("R10 err raised", e, 1);
        repeat (3) @(negedge clk);
        check("R10 err held while idle", err, 1);
    endtask

    initial begin
        for (int k = 0; k < 20; k++) wb[k] = 8'h00;
        clear_rb();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_counts();
        t_rmw();
        t_reject();
        t_range();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule